// File: doc/BRIEF.md
# Count-Register Conditional Branch Resolver

This unit settles a conditional branch whose destination is held in a 32-bit count register. Each issued branch carries a 5-bit option code and a 5-bit condition index. The option code decides three things: whether the count register is decremented, whether a zero or non-zero test is applied to the new count, and whether one bit of the 32-bit condition register must be true or false. The unit reports whether the branch is taken and gives the target. It also supplies the count write-back value and the link-register value, each with its own write enable.

All results are registered and appear one clock after the `issue` strobe. A `strict` input turns on form checking. In strict mode, reserved option bits that must be zero raise `bad_form`, and every side effect of that branch is cancelled. In relaxed mode, those bits are treated as don't-care. The lowest option bit is a likelihood hint and never changes a result. The unit touches no exception or condition state.

Top module: `ctr_branch_resolver`

## Requirements
- R1: One clock after an issue, `target` equals `ctr` with its two low bits cleared, using the count value before decrement. While `issue` is low, `target`, `ctr_out` and `lr_val` hold their previous values.
- R2: The condition bit is `cr[31 - cr_idx]`, so index 0 is the most significant bit. Field k occupies indices 4k..4k+3 and holds LT, GT, EQ and SO in that order.
- R3: Option codes 0000y and 0001y decrement the count. They take the branch when the condition bit is 0 and the new count is non-zero (0000y) or zero (0001y).
- R4: Option codes 001zy and 011zy leave the count alone. They take the branch when the condition bit is 0 (001zy) or 1 (011zy).
- R5: Option codes 0100y and 0101y decrement the count. They take the branch when the condition bit is 1 and the new count is non-zero (0100y) or zero (0101y).
- R6: Option codes 1z00y and 1z01y decrement the count and ignore the condition bit. They take the branch when the new count is non-zero (1z00y) or zero (1z01y).
- R7: Option codes 1z1zz never touch the count and always take the branch.
- R8: `ctr_we` is 1 exactly when an issued, valid branch has option bit 2 equal to 0. `ctr_out` is `ctr - 1`, and zero wraps to all ones.
- R9: When `link` is 1 on a valid issued branch, `lr_we` is 1 and `lr_val` is `pc + 4`, wrapping modulo 2^32. When `link` is 0, `lr_we` is 0.
- R10: Option bit 0 (y) has no effect on any output.
- R11: With `strict` = 1, `bad_form` rises in these cases: bit 1 is set in a code of form 001zy or 011zy; bit 3 is set in any code starting with 1; bit 1 is set in a 1z1zz code. With `strict` = 0, `bad_form` stays 0.
- R12: When `bad_form` is 1, `taken`, `ctr_we` and `lr_we` are 0.
- R13: A cycle without `issue` drives `taken`, `ctr_we`, `lr_we` and `bad_form` to 0 on the next clock.
- R14: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| issue | input | 1 | A branch is presented this cycle |
| opt | input | 5 | Branch option code; bit 4 is the leftmost character of the code |
| cr_idx | input | 5 | Condition-bit index, big-endian numbering |
| link | input | 1 | Request a link-register update |
| cr | input | 32 | Condition register |
| ctr | input | 32 | Count register |
| pc | input | 32 | Address of the branch instruction |
| strict | input | 1 | 1 = check reserved option bits |
| taken | output | 1 | Branch taken |
| target | output | 32 | Branch destination |
| ctr_out | output | 32 | Decremented count value |
| ctr_we | output | 1 | Count write enable |
| lr_val | output | 32 | Link-register value |
| lr_we | output | 1 | Link write enable |
| bad_form | output | 1 | Invalid option form (strict mode only) |

## Verification
The bench sweeps all 32 option codes in both checking modes and both link settings. It uses count values of 0, 1, 2 and a large odd value. With a count of 0 the decrement must wrap to all ones, and a design that tested the old count instead of the new one would take the wrong branches for 1 and 0. A walking-bit sweep over all 32 condition indices catches a little-endian index, which would pick the mirror bit. Hint-bit pairs must match exactly, and reserved-bit cases in strict mode must clear every enable. A link address at the top of memory must wrap to zero.

// File: rtl/ctrb_pkg.sv
package ctrb_pkg;
  localparam int unsigned OPT_W = 5;

  // Option bit positions (bit 4 is the leftmost character of the code)
  localparam int unsigned OB_IGN_COND = 4;
  localparam int unsigned OB_SENSE    = 3;
  localparam int unsigned OB_KEEP_CTR = 2;
  localparam int unsigned OB_ZERO     = 1;
  localparam int unsigned OB_HINT     = 0;

  typedef struct packed {
    logic ign_cond;   // condition bit not consulted
    logic sense;      // required condition value
    logic keep_ctr;   // counter neither decremented nor tested
    logic want_zero;  // branch on new count == 0 (else != 0)
    logic z_err;      // reserved bit set while strict
  } opt_dec_t;
endpackage

// File: rtl/ctrb_opt_decode.sv
module ctrb_opt_decode
  import ctrb_pkg::*;
(
  input  logic [OPT_W-1:0] opt_i,
  input  logic             strict_i,
  output opt_dec_t         dec_o
);
  logic z_any;
  logic unused_hint;

  assign unused_hint = opt_i[OB_HINT];

  // Reserved-bit positions depend on the code family
  always_comb begin
    z_any = 1'b0;
    if (opt_i[OB_IGN_COND]) begin
      z_any = opt_i[OB_SENSE];
      if (opt_i[OB_KEEP_CTR]) z_any = z_any | opt_i[OB_ZERO];
    end else if (opt_i[OB_KEEP_CTR]) begin
      z_any = opt_i[OB_ZERO];
    end
  end

  always_comb begin
    dec_o.ign_cond  = opt_i[OB_IGN_COND];
    dec_o.sense     = opt_i[OB_SENSE];
    dec_o.keep_ctr  = opt_i[OB_KEEP_CTR];
    dec_o.want_zero = opt_i[OB_ZERO];
    dec_o.z_err     = strict_i & z_any;
  end
endmodule

// File: rtl/ctrb_cond_pick.sv
module ctrb_cond_pick #(
  parameter int unsigned CR_W  = 32,
  localparam int unsigned IDX_W = $clog2(CR_W)
) (
  input  logic [CR_W-1:0]  cr_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             bit_o
);
  // Reverse so that index 0 addresses the most significant bit
  logic [CR_W-1:0] cr_be;

  for (genvar g = 0; g < CR_W; g++) begin : g_rev
    assign cr_be[g] = cr_i[CR_W-1-g];
  end

  assign bit_o = cr_be[idx_i];
endmodule

// File: rtl/ctrb_ctr_unit.sv
module ctrb_ctr_unit #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] ctr_i,
  output logic [XLEN-1:0] ctr_dec_o,
  output logic            dec_zero_o
);
  localparam logic [XLEN-1:0] ONE = XLEN'(1);

  assign ctr_dec_o  = ctr_i - ONE;         // wraps 0 -> all ones
  assign dec_zero_o = (ctr_i == ONE);      // new count is zero
endmodule

// File: rtl/ctr_branch_resolver.sv
module ctr_branch_resolver
  import ctrb_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned CR_W       = 32,
  parameter int unsigned INSN_BYTES = 4,
  localparam int unsigned IDX_W     = $clog2(CR_W),
  localparam int unsigned ALIGN     = $clog2(INSN_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [OPT_W-1:0] opt,
  input  logic [IDX_W-1:0] cr_idx,
  input  logic             link,
  input  logic [CR_W-1:0]  cr,
  input  logic [XLEN-1:0]  ctr,
  input  logic [XLEN-1:0]  pc,
  input  logic             strict,
  output logic             taken,
  output logic [XLEN-1:0]  target,
  output logic [XLEN-1:0]  ctr_out,
  output logic             ctr_we,
  output logic [XLEN-1:0]  lr_val,
  output logic             lr_we,
  output logic             bad_form
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] ONE  = XLEN'(1);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  // Sub-blocks
  opt_dec_t        dec;
  logic            cond_bit;
  logic [XLEN-1:0] ctr_dec;
  logic            dec_zero;

  ctrb_opt_decode u_dec (
    .opt_i    (opt),
    .strict_i (strict),
    .dec_o    (dec)
  );

  ctrb_cond_pick #(.CR_W(CR_W)) u_cond (
    .cr_i  (cr),
    .idx_i (cr_idx),
    .bit_o (cond_bit)
  );

  ctrb_ctr_unit #(.XLEN(XLEN)) u_ctr (
    .ctr_i      (ctr),
    .ctr_dec_o  (ctr_dec),
    .dec_zero_o (dec_zero)
  );

  // Next-state logic
  logic            cond_ok, cnt_ok, ok;
  logic            taken_d, ctr_we_d, lr_we_d, bad_d;
  logic [XLEN-1:0] target_d, lr_val_d;

  always_comb begin
    cond_ok  = dec.ign_cond | (cond_bit == dec.sense);
    cnt_ok   = dec.keep_ctr | (dec.want_zero ? dec_zero : ~dec_zero);
    ok       = issue & ~dec.z_err;
    taken_d  = ok & cond_ok & cnt_ok;
    ctr_we_d = ok & ~dec.keep_ctr;
    lr_we_d  = ok & link;
    bad_d    = issue & dec.z_err;
    target_d = {ctr[XLEN-1:ALIGN], {ALIGN{1'b0}}};
    lr_val_d = pc + STEP;
  end

  // Flags: updated every cycle
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      taken    <= 1'b0;
      ctr_we   <= 1'b0;
      lr_we    <= 1'b0;
      bad_form <= 1'b0;
    end else begin
      taken    <= taken_d;
      ctr_we   <= ctr_we_d;
      lr_we    <= lr_we_d;
      bad_form <= bad_d;
    end
  end

  // Data: clock-enabled by issue
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      target  <= '0;
      ctr_out <= '0;
      lr_val  <= '0;
    end else if (issue) begin
      target  <= target_d;
      ctr_out <= ctr_dec;
      lr_val  <= lr_val_d;
    end
  end

  // R12
  bad_form_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    bad_form |-> (!taken && !ctr_we && !lr_we));

  // R8
  ctr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ctr_we |-> (ctr_out == $past(ctr) - ONE));

  // R9
  link_value_chk: assert property (@(posedge clk) disable iff (!rst_q)
    lr_we |-> (lr_val == $past(pc) + STEP));

  // R3 R4 R5
  cond_sense_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (taken && !$past(opt[OB_IGN_COND])) |-> ($past(cond_bit) == $past(opt[OB_SENSE])));

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !issue |=> (!taken && !ctr_we && !lr_we && !bad_form));
endmodule

// File: tb/ctr_branch_resolver_bench.sv
module ctr_branch_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [4:0]  opt;
  logic [4:0]  cr_idx;
  logic        link;
  logic [31:0] cr;
  logic [31:0] ctr;
  logic [31:0] pc;
  logic        strict;
  logic        taken;
  logic [31:0] target;
  logic [31:0] ctr_out;
  logic        ctr_we;
  logic [31:0] lr_val;
  logic        lr_we;
  logic        bad_form;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  ctr_branch_resolver u_ctr_branch_resolver (
    .clk(clk), .rst_n(rst_n), .issue(issue), .opt(opt), .cr_idx(cr_idx),
    .link(link), .cr(cr), .ctr(ctr), .pc(pc), .strict(strict),
    .taken(taken), .target(target), .ctr_out(ctr_out), .ctr_we(ctr_we),
    .lr_val(lr_val), .lr_we(lr_we), .bad_form(bad_form)
  );

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Reference model written from the requirement table
  task automatic model(input logic [4:0] o, input logic s, input logic lk,
                       input logic cbit, input logic [31:0] c,
                       output logic tk, output logic cwe, output logic lwe,
                       output logic bad);
    logic        dec, need_cond, cval, need_cnt, want_z, always_tk, z;
    logic [31:0] nc;
    nc = c - 32'd1;
    dec = 0; need_cond = 0; cval = 0; need_cnt = 0; want_z = 0; always_tk = 0; z = 0;
    casez (o)
      5'b0000?: begin dec = 1; need_cond = 1; cval = 0; need_cnt = 1; want_z = 0; end // R3
      5'b0001?: begin dec = 1; need_cond = 1; cval = 0; need_cnt = 1; want_z = 1; end // R3
      5'b001??: begin need_cond = 1; cval = 0; z = o[1]; end                        // R4
      5'b0100?: begin dec = 1; need_cond = 1; cval = 1; need_cnt = 1; want_z = 0; end // R5
      5'b0101?: begin dec = 1; need_cond = 1; cval = 1; need_cnt = 1; want_z = 1; end // R5
      5'b011??: begin need_cond = 1; cval = 1; z = o[1]; end                        // R4
      5'b1?00?: begin dec = 1; need_cnt = 1; want_z = 0; z = o[3]; end              // R6
      5'b1?01?: begin dec = 1; need_cnt = 1; want_z = 1; z = o[3]; end              // R6
      default:  begin always_tk = 1; z = o[3] | o[1]; end                           // R7
    endcase
    bad = s & z;                                                                     // R11
    tk  = !bad && (always_tk ||
          ((!need_cond || cbit == cval) && (!need_cnt || ((nc == 0) == want_z))));
    cwe = !bad && dec;                                                               // R8
    lwe = !bad && lk;                                                                // R9
  endtask

  initial begin
    #200000;  // 40,000 cycles
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] ctr_set [4];
    logic        e_tk, e_cwe, e_lwe, e_bad;
    logic        e_tk2, e_cwe2, e_lwe2, e_bad2;
    int          k;
    ctr_set[0] = 32'h0000_0000; ctr_set[1] = 32'h0000_0001;
    ctr_set[2] = 32'h0000_0002; ctr_set[3] = 32'h8000_0007;

    rst_n = 0; issue = 0; opt = 0; cr_idx = 0; link = 0; cr = 0; ctr = 0;
    pc = 0; strict = 0;
    repeat (3) @(negedge clk);
    // R14: outputs zero during reset
    cmp("R14", {taken, ctr_we, lr_we, bad_form}, 0);
    cmp("R14", target | ctr_out | lr_val, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp("R14", {taken, ctr_we, lr_we, bad_form}, 0);
    cmp("R14", target | ctr_out | lr_val, 0);

    // Main sweep: every option code, both modes, both link values, four counts
    k = 0;
    for (int o = 0; o < 32; o++) begin
      for (int s = 0; s < 2; s++) begin
        for (int l = 0; l < 2; l++) begin
          for (int ci = 0; ci < 4; ci++) begin
            logic cbit;
            issue = 1; opt = 5'(o); strict = s[0]; link = l[0];
            ctr = ctr_set[ci];
            cr = (k % 2 == 0) ? 32'hA5C3_1E96 : 32'h5A3C_E169;
            cr_idx = 5'((k * 7) % 32);
            pc = (k == 5) ? 32'hFFFF_FFFC : 32'h0000_1000 + 32'(k) * 4;
            cbit = cr[31 - int'(cr_idx)];  // R2
            model(opt, strict, link, cbit, ctr, e_tk, e_cwe, e_lwe, e_bad);
            @(negedge clk);
            cmp("R3-R7 taken", {31'b0, taken}, {31'b0, e_tk});
            cmp("R8 ctr_we", {31'b0, ctr_we}, {31'b0, e_cwe});
            cmp("R9 lr_we", {31'b0, lr_we}, {31'b0, e_lwe});
            cmp("R11 bad_form", {31'b0, bad_form}, {31'b0, e_bad});
            cmp("R1 target", target, {ctr[31:2], 2'b00});
            cmp("R8 ctr_out", ctr_out, ctr - 32'd1);
            cmp("R9 lr_val", lr_val, pc + 32'd4);
            if (bad_form) cmp("R12", {29'b0, taken, ctr_we, lr_we}, 0);
            // R10: the hint-bit twin must model identically
            model(opt ^ 5'b00001, strict, link, cbit, ctr, e_tk2, e_cwe2, e_lwe2, e_bad2);
            cmp("R10", {28'b0, e_tk2, e_cwe2, e_lwe2, e_bad2}, {28'b0, e_tk, e_cwe, e_lwe, e_bad});
            k++;
          end
        end
      end
    end

    // R10 at the ports: same branch with y = 0 and y = 1
    for (int y = 0; y < 2; y++) begin
      issue = 1; strict = 1; link = 1; opt = {4'b0100, y[0]};
      cr = 32'h8000_0000; cr_idx = 0; ctr = 32'h0000_0003; pc = 32'h40;
      @(negedge clk);
      cmp("R10 taken", {31'b0, taken}, 32'd1);
      cmp("R10 ctr_out", ctr_out, 32'h0000_0002);
    end

    // R2: walking condition bit over all indices, branch on true (01100)
    for (int i = 0; i < 32; i++) begin
      issue = 1; strict = 1; link = 0; opt = 5'b01100; ctr = 32'h10;
      cr_idx = 5'(i); cr = 32'h8000_0000 >> i;
      @(negedge clk);
      cmp("R2 selected", {31'b0, taken}, 32'd1);
      cr = ~(32'h8000_0000 >> i);
      @(negedge clk);
      cmp("R2 cleared", {31'b0, taken}, 32'd0);
    end

    // R13: no issue -> flags drop, data registers hold
    issue = 1; opt = 5'b10100; strict = 0; link = 1; ctr = 32'h0000_1234;
    pc = 32'h200; cr = 0; cr_idx = 0;
    @(negedge clk);
    cmp("R7 always", {31'b0, taken}, 32'd1);
    issue = 0; ctr = 32'hDEAD_BEEF; pc = 32'h900;
    @(negedge clk);
    cmp("R13 flags", {28'b0, taken, ctr_we, lr_we, bad_form}, 0);
    cmp("R1 hold target", target, 32'h0000_1234);
    cmp("R1 hold lr_val", lr_val, 32'h0000_0204);

    finish_run();
  end
endmodule